// File: doc/BRIEF.md
# DDR Power-Up Command Sequencer

This block brings an external DDR1 or DDR2 memory device from power-up to a usable state. After reset is released it latches two configuration straps. One strap selects the memory generation. The other gives the reference clock frequency. The block then steps through a fixed list of commands toward the memory PHY.

Each command is one-hot coded and may carry a mode-register value. The command is held on the interface until the PHY acknowledges it, and the next command is presented only after that acknowledge.

For DDR2, a configuration word is pulsed first. It carries the DDR2 enable, the write latency, on-die termination and the four-activate window. When the last mode-register write is acknowledged, the block loads the refresh word. One cycle later it raises `init_done` and holds it there until the next reset.

Top module: `ddr_init_seq`

## Requirements
- R1: `strap_ddr2` and `strap_ref40` are sampled only in the first cycle after reset is released. Changing them later does not alter the command list or the refresh word.
- R2: With `strap_ddr2`=1 the commands are, in this order:
  - precharge-all;
  - EMR2 with 0x000, then EMR3 with 0x000;
  - EMR with 0x000;
  - MRS with 0x100;
  - precharge-all;
  - auto-refresh twice;
  - MRS with 0xA33;
  - EMR with 0x382, then EMR with 0x402.
- R3: With `strap_ddr2`=0 the commands are, in this order: precharge-all, MRS with 0x133, EMR with 0x002, precharge-all, then MRS with 0x033.
- R4: `cmd_code` is one-hot whenever `cmd_valid` is high:
  - bit0 = MRS;
  - bit1 = EMR;
  - bit2 = auto-refresh;
  - bit3 = precharge-all;
  - bit4 = EMR2;
  - bit5 = EMR3.

  `cmd_mr` is 0 for precharge and auto-refresh.
- R5: While `cmd_valid` is high and `cmd_ack` is low, `cmd_valid`, `cmd_code` and `cmd_mr` stay unchanged. The next command is presented in the cycle after the acknowledge.
- R6: In DDR2 mode, `cfg_load` pulses for one cycle before the first command, with `cfg_word`=0xA59. The fields are: enable at bit0, tFAW=22 in bits 7:2, ODT at bit9, and write latency 2 in bits 13:10. In DDR1 mode `cfg_load` never rises.
- R7: The refresh word has the enable at bit 14 and the interval in bits 9:0. It is 0x4270 (interval 624) when `strap_ref40`=1, and 0x4186 (interval 390) otherwise.
- R8: `ref_load` pulses in the cycle after the final command is acknowledged. `refresh_word` is 0 until that pulse has taken effect.
- R9: `init_done` is low during the sequence. It rises one cycle after `ref_load`, together with the new `refresh_word`, and then stays high with no further commands.
- R10: During reset all outputs are 0. A reset at any point restarts the sequence from its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_ddr2 | input | 1 | 1 selects the DDR2 sequence |
| strap_ref40 | input | 1 | 1 means a 40 MHz reference, 0 means 25 MHz |
| cmd_ack | input | 1 | PHY has accepted the presented command |
| cmd_valid | output | 1 | A command is presented |
| cmd_code | output | 6 | One-hot command code |
| cmd_mr | output | 13 | Mode-register value for the command |
| cfg_load | output | 1 | One-cycle DDR2 configuration strobe |
| cfg_word | output | 14 | DDR2 configuration word, valid with `cfg_load` |
| ref_load | output | 1 | One-cycle refresh-load strobe |
| refresh_word | output | 15 | Applied refresh setting |
| init_done | output | 1 | Initialization complete |

## Verification
A corrupted step index or mode latch shows at the ports on the very next command presented. The code or mode-register value diverges from the expected list at that step, or the list length changes, so the refresh strobe arrives early or late. A wrong state encoding shows within one cycle as `cmd_valid` dropping without an acknowledge, or as `init_done` rising with no preceding load strobe. A strap latched at the wrong time shows as a wrong first command, or as a refresh word that follows a strap changed mid-sequence.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

    localparam int CMD_W   = 6;
    localparam int MR_W    = 13;
    localparam int CFG_W   = 14;
    localparam int REF_W   = 15;
    localparam int INT_W   = 10;
    localparam int REF_EN_BIT = 14;
    localparam int IDX_W   = 4;

    localparam int DDR2_STEPS = 11;
    localparam int DDR1_STEPS = 5;

    typedef logic [CMD_W-1:0] cmd_t;

    localparam cmd_t CMD_MRS  = 6'b000001;
    localparam cmd_t CMD_EMR  = 6'b000010;
    localparam cmd_t CMD_AREF = 6'b000100;
    localparam cmd_t CMD_PALL = 6'b001000;
    localparam cmd_t CMD_EMR2 = 6'b010000;
    localparam cmd_t CMD_EMR3 = 6'b100000;

    typedef struct packed {
        cmd_t            code;
        logic [MR_W-1:0] mr;
    } step_t;

    typedef enum logic [2:0] {
        S_START,
        S_CFG,
        S_CMD,
        S_REF,
        S_DONE
    } seq_state_t;

    // DDR2 configuration fields
    localparam int CFG_TWL   = 2;
    localparam int CFG_TFAW  = 22;
    localparam logic [CFG_W-1:0] DDR2_CFG_WORD =
        CFG_W'(CFG_TWL << 10) | CFG_W'(1 << 9) | CFG_W'(CFG_TFAW << 2) | CFG_W'(1);

    function automatic step_t mk(cmd_t c, logic [MR_W-1:0] v);
        step_t s;
        s.code = c;
        s.mr   = v;
        return s;
    endfunction

    function automatic step_t ddr2_step(logic [IDX_W-1:0] i);
        case (i)
            4'd0:    return mk(CMD_PALL, 13'h000);
            4'd1:    return mk(CMD_EMR2, 13'h000);
            4'd2:    return mk(CMD_EMR3, 13'h000);
            4'd3:    return mk(CMD_EMR,  13'h000);
            4'd4:    return mk(CMD_MRS,  13'h100);
            4'd5:    return mk(CMD_PALL, 13'h000);
            4'd6:    return mk(CMD_AREF, 13'h000);
            4'd7:    return mk(CMD_AREF, 13'h000);
            4'd8:    return mk(CMD_MRS,  13'hA33);
            4'd9:    return mk(CMD_EMR,  13'h382);
            4'd10:   return mk(CMD_EMR,  13'h402);
            default: return mk('0, '0);
        endcase
    endfunction

    function automatic step_t ddr1_step(logic [IDX_W-1:0] i);
        case (i)
            4'd0:    return mk(CMD_PALL, 13'h000);
            4'd1:    return mk(CMD_MRS,  13'h133);
            4'd2:    return mk(CMD_EMR,  13'h002);
            4'd3:    return mk(CMD_PALL, 13'h000);
            4'd4:    return mk(CMD_MRS,  13'h033);
            default: return mk('0, '0);
        endcase
    endfunction

endpackage

// File: rtl/ddr_seq_rom.sv
module ddr_seq_rom
    import ddr_seq_pkg::*;
(
    input  logic             mode_ddr2,
    input  logic [IDX_W-1:0] idx,
    output step_t            step,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST2 = IDX_W'(DDR2_STEPS - 1);
    localparam logic [IDX_W-1:0] LAST1 = IDX_W'(DDR1_STEPS - 1);

    always_comb begin
        if (mode_ddr2) begin
            step = ddr2_step(idx);
            last = (idx == LAST2);
        end else begin
            step = ddr1_step(idx);
            last = (idx == LAST1);
        end
    end
endmodule

// File: rtl/ddr_seq_fsm.sv
module ddr_seq_fsm
    import ddr_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_ddr2,
    input  logic             strap_ref40,
    input  logic             cmd_ack,
    input  logic             last_step,
    output logic [IDX_W-1:0] idx,
    output logic             mode_ddr2,
    output logic             ref40,
    output logic             cmd_valid,
    output logic             cfg_load,
    output logic             ref_load,
    output logic             init_done
);
    seq_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_START;
            idx       <= '0;
            mode_ddr2 <= 1'b0;
            ref40     <= 1'b0;
        end else begin
            case (state)
                S_START: begin
                    mode_ddr2 <= strap_ddr2;
                    ref40     <= strap_ref40;
                    idx       <= '0;
                    state     <= strap_ddr2 ? S_CFG : S_CMD;
                end
                S_CFG:  state <= S_CMD;
                S_CMD: begin
                    if (cmd_ack) begin
                        if (last_step) state <= S_REF;
                        else           idx   <= idx + 1'b1;
                    end
                end
                S_REF:  state <= S_DONE;
                S_DONE: state <= S_DONE;
                default: state <= S_START;
            endcase
        end
    end

    always_comb begin
        cmd_valid = (state == S_CMD);
        cfg_load  = (state == S_CFG);
        ref_load  = (state == S_REF);
        init_done = (state == S_DONE);
    end
endmodule

// File: rtl/ddr_refresh_reg.sv
module ddr_refresh_reg
    import ddr_seq_pkg::*;
#(
    parameter int INTERVAL_FAST = 624,
    parameter int INTERVAL_SLOW = 390
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             ref40,
    output logic [REF_W-1:0] word
);
    logic [INT_W-1:0] interval;

    assign interval = ref40 ? INT_W'(INTERVAL_FAST) : INT_W'(INTERVAL_SLOW);

    always_ff @(posedge clk) begin
        if (rst)
            word <= '0;
        else if (load)
            word <= REF_W'(1 << REF_EN_BIT) | REF_W'(interval);
    end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_seq_pkg::*;
#(
    parameter int INTERVAL_FAST = 624,
    parameter int INTERVAL_SLOW = 390
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_ddr2,
    input  logic             strap_ref40,
    input  logic             cmd_ack,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_code,
    output logic [MR_W-1:0]  cmd_mr,
    output logic             cfg_load,
    output logic [CFG_W-1:0] cfg_word,
    output logic             ref_load,
    output logic [REF_W-1:0] refresh_word,
    output logic             init_done
);
    logic [IDX_W-1:0] idx;
    logic             mode_ddr2;
    logic             ref40;
    logic             last_step;
    step_t            step;

    ddr_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .strap_ddr2 (strap_ddr2),
        .strap_ref40(strap_ref40),
        .cmd_ack    (cmd_ack),
        .last_step  (last_step),
        .idx        (idx),
        .mode_ddr2  (mode_ddr2),
        .ref40      (ref40),
        .cmd_valid  (cmd_valid),
        .cfg_load   (cfg_load),
        .ref_load   (ref_load),
        .init_done  (init_done)
    );

    ddr_seq_rom u_rom (
        .mode_ddr2(mode_ddr2),
        .idx      (idx),
        .step     (step),
        .last     (last_step)
    );

    ddr_refresh_reg #(
        .INTERVAL_FAST(INTERVAL_FAST),
        .INTERVAL_SLOW(INTERVAL_SLOW)
    ) u_ref (
        .clk  (clk),
        .rst  (rst),
        .load (ref_load),
        .ref40(ref40),
        .word (refresh_word)
    );

    assign cmd_code = cmd_valid ? step.code : '0;
    assign cmd_mr   = cmd_valid ? step.mr   : '0;
    assign cfg_word = cfg_load  ? DDR2_CFG_WORD : '0;
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk
    import ddr_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmd_ack,
    input logic             cmd_valid,
    input logic [CMD_W-1:0] cmd_code,
    input logic [MR_W-1:0]  cmd_mr,
    input logic             cfg_load,
    input logic             ref_load,
    input logic [REF_W-1:0] refresh_word,
    input logic             init_done
);
    // R4
    onehot_code_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $onehot(cmd_code));

    // R5
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_mr)));

    // R6
    cfg_not_with_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> !cfg_load);

    // R7
    refresh_enable_chk: assert property (@(posedge clk) disable iff (rst)
        ref_load |=> refresh_word[REF_EN_BIT]);

    // R8
    refresh_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ref_load |-> $past(cmd_valid && cmd_ack));

    // R9
    done_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> $past(ref_load));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && !cmd_valid));
endmodule

bind ddr_init_seq ddr_init_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_ack     (cmd_ack),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_mr      (cmd_mr),
    .cfg_load    (cfg_load),
    .ref_load    (ref_load),
    .refresh_word(refresh_word),
    .init_done   (init_done)
);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_ddr2 = 1'b0;
    logic        strap_ref40 = 1'b0;
    logic        cmd_ack = 1'b0;
    logic        cmd_valid;
    logic [5:0]  cmd_code;
    logic [12:0] cmd_mr;
    logic        cfg_load;
    logic [13:0] cfg_word;
    logic        ref_load;
    logic [14:0] refresh_word;
    logic        init_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ddr_init_seq u0 (
        .clk(clk), .rst(rst), .strap_ddr2(strap_ddr2), .strap_ref40(strap_ref40),
        .cmd_ack(cmd_ack), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_mr(cmd_mr),
        .cfg_load(cfg_load), .cfg_word(cfg_word), .ref_load(ref_load),
        .refresh_word(refresh_word), .init_done(init_done)
    );

    // {code[5:0], mr[12:0]}: entries 0..10 DDR2 (R2), 11..15 DDR1 (R3)
    localparam logic [18:0] EXP [16] = '{
        {6'h08, 13'h000}, {6'h10, 13'h000}, {6'h20, 13'h000}, {6'h02, 13'h000},
        {6'h01, 13'h100}, {6'h08, 13'h000}, {6'h04, 13'h000}, {6'h04, 13'h000},
        {6'h01, 13'hA33}, {6'h02, 13'h382}, {6'h02, 13'h402},
        {6'h08, 13'h000}, {6'h01, 13'h133}, {6'h02, 13'h002}, {6'h08, 13'h000},
        {6'h01, 13'h033}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit d2, input bit r40);
        rst = 1'b1;
        cmd_ack = 1'b0;
        strap_ddr2 = d2;
        strap_ref40 = r40;
        repeat (3) @(negedge clk);
        // R10 outputs low in reset
        chk("R10 reset outputs",
            32'({cmd_valid, cmd_code, cmd_mr, cfg_load, ref_load, refresh_word, init_done}), 32'd0);
        rst = 1'b0;
    endtask

    // stop_after < 0 runs to completion
    task automatic run_seq(input bit d2, input bit r40, input int hold, input bit flip,
                           input int stop_after);
        int base = d2 ? 0 : 11;
        int n = d2 ? 11 : 5;
        bit cfg_seen = 0;
        do_reset(d2, r40);
        for (int k = 0; k < n; k++) begin
            int w = 0;
            if (stop_after >= 0 && k == stop_after) return;
            if (flip && k == 1) begin
                strap_ddr2 = ~d2;
                strap_ref40 = ~r40;
            end
            while (!cmd_valid && w < 30) begin
                @(negedge clk);
                if (cfg_load) begin
                    cfg_seen = 1;
                    chk("R6 cfg word", 32'(cfg_word), 32'h0A59);
                    chk("R6 no cmd with cfg", 32'(cmd_valid), 32'd0);
                end
                w++;
            end
            if (k == 0) chk("R6 cfg pulse presence", 32'(cfg_seen), 32'(d2));
            chk(d2 ? "R2 ddr2 step" : "R3 ddr1 step", 32'({cmd_valid, cmd_code, cmd_mr}),
                32'({1'b1, EXP[base+k]}));
            chk("R8 no refresh during seq", 32'({init_done, refresh_word}), 32'd0);
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                chk("R5 held without ack", 32'({cmd_valid, cmd_code, cmd_mr}),
                    32'({1'b1, EXP[base+k]}));
            end
            cmd_ack = 1'b1;
            @(negedge clk);
            cmd_ack = 1'b0;
            if (k < n - 1)
                chk("R5 next cmd after ack", 32'({cmd_valid, cmd_code, cmd_mr}),
                    32'({1'b1, EXP[base+k+1]}));
        end
        chk("R8 ref_load after last ack", 32'({ref_load, cmd_valid, init_done}), 32'b100);
        chk("R8 word not yet applied", 32'(refresh_word), 32'd0);
        @(negedge clk);
        chk("R9 done one cycle after load", 32'({init_done, ref_load}), 32'b10);
        chk(flip ? "R1 strap held, R7 refresh" : "R7 refresh word", 32'(refresh_word),
            r40 ? 32'h4270 : 32'h4186);
        repeat (5) @(negedge clk);
        chk("R9 done sticky, idle", 32'({init_done, cmd_valid, cfg_load, ref_load}), 32'b1000);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // table-driven runs over both sequences
        run_seq(1'b1, 1'b1, 0, 1'b0, -1);
        run_seq(1'b0, 1'b0, 0, 1'b0, -1);
        run_seq(1'b1, 1'b0, 3, 1'b0, -1);
        run_seq(1'b0, 1'b1, 2, 1'b0, -1);
        // R1 straps flipped mid-sequence
        run_seq(1'b1, 1'b1, 1, 1'b1, -1);
        run_seq(1'b0, 1'b0, 1, 1'b1, -1);
        // R10 reset mid-sequence restarts from first step
        run_seq(1'b1, 1'b0, 0, 1'b0, 5);
        run_seq(1'b0, 1'b1, 0, 1'b0, -1);
        run_seq(1'b0, 1'b0, 0, 1'b0, 3);
        run_seq(1'b1, 1'b1, 0, 1'b0, -1);
        // R4 no command after done, even with a stray ack
        cmd_ack = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0;
        @(negedge clk);
        chk("R4 stray ack ignored", 32'({cmd_valid, cmd_code, init_done}), 32'd1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule